// File: doc/BRIEF.md
# Sample-Count PWM Interrupt Timer

This block raises a periodic interrupt whose rate is set in PWM sample periods rather than in raw clocks. A period counter walks through one PWM sample period, which a 12-bit cycle register sets. Each time that counter wraps, one sample is complete. A sample counter adds up the completed samples. Whenever the total reaches the interval held in a 4-bit field of the control register, the block sets a level-sensitive interrupt flag.

A host drives a single write port that selects one of three registers by address. The control register carries the interval. A write to the cycle register sets the period and also restarts the sample count. A write to the clear register drops the flag. The flag stays high until software clears it, so an interrupt controller can sample it as a level.

Top module: `pwmirq_timer`

## Requirements
- R1: After reset, `irq` is low, the interval is 0 and the stored cycle value is 0. With no writes, `irq` stays low.
- R2: A write to address 1 (cycle) keeps only `wr_data[11:0]`. The upper data bits have no effect. A stored value C gives a sample length of ((C-1) mod 4096)+1 clocks, so C=1 gives 1 clock and C=0 gives 4096 clocks.
- R3: A write to address 0 (control) takes the interval N from `wr_data[11:8]`. All other data bits of that write are ignored.
- R4: The sample count rises by one at each wrap of the period counter. With interval N and sample length L, set by a cycle write at clock edge E0, the flag sets at edges E0+N·L, E0+2N·L, and so on. `irq` is high from the clock after that edge.
- R5: When a wrap brings count+1 to N or above, N is subtracted and the remainder is kept. After the interval is lowered below the running count, interrupts therefore fire on consecutive samples until the excess is used up.
- R6: While N is 0, no interrupt is raised and the sample count holds its value.
- R7: A cycle write sets the sample count to zero and restarts the period counter. A wrap at that same edge is not counted.
- R8: Once set, `irq` stays high until a write to address 2 (clear), whatever the data. It is low from the clock after that write, unless an interval completes at the same edge, in which case it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 cycle, 2 interrupt clear |
| wr_data | input | 16 | Write data |
| irq | output | 1 | Level interrupt request flag |

## Verification
Each result is due at a fixed edge. A register write takes effect at the edge that samples it. The flag is registered once, so `irq` rises one clock after the edge at which the N-th wrap is counted, which is edge E0+N·L after the cycle write. A clear lands at the edge that samples it. The bench counts edges from the cycle write and samples `irq` at the falling edge after each rising edge. It compares that sample with the closed form "high once t ≥ m·N·L", where m·N·L is the first completion at or after the latest clear. This comparison runs over every C from 1 to 5 against every N from 1 to 4, plus C=0. Hand-derived edge schedules cover the disabled, remainder-carry and restart cases.

// File: rtl/pwmirq_pkg.sv
package pwmirq_pkg;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_CYC_W    = 12;
  localparam int DEF_INTV_W   = 4;
  localparam int DEF_INTV_LSB = 8;

  // Register selection on the write port
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CYCLE = 2'd1,
    SEL_ICLR  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwmirq_regs.sv
module pwmirq_regs
  import pwmirq_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int CYC_W    = DEF_CYC_W,
  parameter int INTV_W   = DEF_INTV_W,
  parameter int INTV_LSB = DEF_INTV_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CYC_W-1:0]  cyc_q,
  output logic [INTV_W-1:0] intv_q,
  output logic              cyc_wr,
  output logic              clr_wr
);
  localparam int INTV_MSB = INTV_LSB + INTV_W - 1;

  reg_sel_e sel;
  logic     ctrl_wr;

  assign sel     = reg_sel_e'(wr_addr);
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign cyc_wr  = wr_en && (sel == SEL_CYCLE);
  assign clr_wr  = wr_en && (sel == SEL_ICLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      intv_q <= '0;
    end else begin
      if (cyc_wr)  cyc_q  <= wr_data[CYC_W-1:0];
      if (ctrl_wr) intv_q <= wr_data[INTV_MSB:INTV_LSB];
    end
  end
endmodule

// File: rtl/pwmirq_period.sv
module pwmirq_period #(
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cyc_q,
  input  logic             restart,
  output logic [CYC_W-1:0] pcnt,
  output logic             sample_wrap
);
  // Last tick index of a sample: cycle value minus one, modulo 2^CYC_W
  function automatic logic [CYC_W-1:0] last_tick(input logic [CYC_W-1:0] cyc);
    return cyc - 1'b1;
  endfunction

  assign sample_wrap = (pcnt == last_tick(cyc_q));

  always_ff @(posedge clk) begin
    if (!rst_n)           pcnt <= '0;
    else if (restart)     pcnt <= '0;
    else if (sample_wrap) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pwmirq_accum.sv
module pwmirq_accum #(
  parameter int INTV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INTV_W-1:0] intv,
  input  logic              restart,
  input  logic              sample_wrap,
  output logic [INTV_W-1:0] scnt,
  output logic              fire
);
  localparam int SUM_W = INTV_W + 1;

  function automatic logic [SUM_W-1:0] bump(input logic [INTV_W-1:0] c);
    return {1'b0, c} + 1'b1;
  endfunction

  function automatic logic [INTV_W-1:0] settle(input logic [SUM_W-1:0] total,
                                               input logic [INTV_W-1:0] step,
                                               input logic              hit);
    logic [SUM_W-1:0] rem;
    rem = hit ? (total - {1'b0, step}) : total;
    return rem[INTV_W-1:0];
  endfunction

  logic [SUM_W-1:0] total;
  logic             active;

  assign total  = bump(scnt);
  assign active = sample_wrap && !restart && (intv != '0);
  assign fire   = active && (total >= {1'b0, intv});

  always_ff @(posedge clk) begin
    if (!rst_n)       scnt <= '0;
    else if (restart) scnt <= '0;
    else if (active)  scnt <= settle(total, intv, fire);
  end
endmodule

// File: rtl/pwmirq_timer.sv
module pwmirq_timer
  import pwmirq_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int CYC_W    = DEF_CYC_W,
  parameter int INTV_W   = DEF_INTV_W,
  parameter int INTV_LSB = DEF_INTV_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  logic [CYC_W-1:0]  cyc_q;
  logic [INTV_W-1:0] intv_q;
  logic              cyc_wr;
  logic              clr_wr;
  logic [CYC_W-1:0]  pcnt;
  logic              sample_wrap;
  logic [INTV_W-1:0] scnt;
  logic              fire;
  logic              irq_q;

  pwmirq_regs #(
    .DATA_W(DATA_W), .CYC_W(CYC_W), .INTV_W(INTV_W), .INTV_LSB(INTV_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cyc_q(cyc_q), .intv_q(intv_q),
    .cyc_wr(cyc_wr), .clr_wr(clr_wr)
  );

  pwmirq_period #(.CYC_W(CYC_W)) u_period (
    .clk(clk), .rst_n(rst_n), .cyc_q(cyc_q), .restart(cyc_wr),
    .pcnt(pcnt), .sample_wrap(sample_wrap)
  );

  pwmirq_accum #(.INTV_W(INTV_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .intv(intv_q), .restart(cyc_wr),
    .sample_wrap(sample_wrap), .scnt(scnt), .fire(fire)
  );

  // Set wins over clear when both land on one edge
  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (fire)   irq_q <= 1'b1;
    else if (clr_wr) irq_q <= 1'b0;
  end

  assign irq = irq_q;
endmodule

// File: rtl/pwmirq_timer_chk.sv
module pwmirq_timer_chk #(
  parameter int DATA_W   = 16,
  parameter int CYC_W    = 12,
  parameter int INTV_W   = 4,
  parameter int INTV_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              cyc_wr,
  input logic              clr_wr,
  input logic [CYC_W-1:0]  cyc_q,
  input logic [INTV_W-1:0] intv_q,
  input logic [CYC_W-1:0]  pcnt,
  input logic              sample_wrap,
  input logic [INTV_W-1:0] scnt,
  input logic              fire,
  input logic              irq
);
  localparam int INTV_MSB = INTV_LSB + INTV_W - 1;

  p_cycle_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> cyc_q == $past(wr_data[CYC_W-1:0]));

  p_period_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_wr && !sample_wrap) |=> pcnt == $past(pcnt) + 1'b1);

  p_intv_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> intv_q == $past(wr_data[INTV_MSB:INTV_LSB]));

  p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scnt != {INTV_W{1'b1}});

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_q == '0 && !irq) |=> !irq);

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> (scnt == '0 && pcnt == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !fire) |=> !irq);
endmodule

bind pwmirq_timer pwmirq_timer_chk #(
  .DATA_W(DATA_W), .CYC_W(CYC_W), .INTV_W(INTV_W), .INTV_LSB(INTV_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cyc_wr(cyc_wr), .clr_wr(clr_wr), .cyc_q(cyc_q),
  .intv_q(intv_q), .pcnt(pcnt), .sample_wrap(sample_wrap), .scnt(scnt),
  .fire(fire), .irq(irq)
);

// File: tb/pwmirq_timer_tb.sv
module pwmirq_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmirq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  task automatic check(input logic got, input logic exp, input string req, input int t);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d irq=%b expected=%b", req, t, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  // Advance to the next falling edge and release the write strobe
  task automatic step();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Interval write, cycle write at edge E0, clear at E0+1; returns at t=1
  task automatic start_cfg(input int c, input int n);
    drive(2'd0, 16'h50FF | 16'((n & 15) << 8));  // R3: other bits set
    step();
    drive(2'd1, 16'hA000 | 16'(c & 12'hFFF));    // R2: upper bits set
    step();
    drive(2'd2, 16'h1234);
    step();
  endtask

  // Closed-form sweep over one (C, N) pair
  task automatic run_cfg(input int c, input int n);
    int len, nl, tc, tclr2, m;
    len   = ((c + 4095) % 4096) + 1;
    nl    = n * len;
    tc    = 1;
    tclr2 = 2 * nl + 2;
    start_cfg(c, n);
    for (int t = 1; t <= 3 * nl + 2; t++) begin
      if (t == tclr2) tc = t;
      m = (tc + nl - 1) / nl;
      if (m < 1) m = 1;
      check(irq, (t >= m * nl), (tc == 1) ? "R4/R2" : "R8", t);
      if (t + 1 == tclr2) drive(2'd2, 16'hFFFF);
      step();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1 in reset", 0);
    rst_n = 1'b1;
    step();
    check(irq, 1'b0, "R1 after reset", 0);
    // Reset state: interval 0 and cycle 0, so nothing fires across a full wrap
    repeat (4100) step();
    check(irq, 1'b0, "R1 idle", 4100);

    // Near-exhaustive sweep of small periods and intervals
    for (int c = 1; c <= 5; c++)
      for (int n = 1; n <= 4; n++)
        run_cfg(c, n);
    // Cycle value 0 means 4096 clocks per sample
    run_cfg(0, 1);

    // R6: interval 0 raises nothing and freezes the count
    start_cfg(1, 0);
    for (int t = 1; t <= 46; t++) begin
      check(irq, (t >= 43), "R6", t);
      if (t == 40) drive(2'd0, 16'h0200);
      step();
    end

    // R5: remainder kept after the interval is lowered below the count
    start_cfg(1, 8);
    for (int t = 1; t <= 12; t++) begin
      if (t >= 6) check(irq, (t >= 7 && t <= 9) || t == 12, "R5", t);
      if (t == 5) drive(2'd0, 16'h0300);
      if (t == 9) drive(2'd2, 16'h0000);
      step();
    end

    // R7: cycle write zeroes the sample count
    start_cfg(1, 4);
    for (int t = 1; t <= 8; t++) begin
      if (t >= 3) check(irq, (t >= 7), "R7 count", t);
      if (t == 2) drive(2'd1, 16'h0001);
      step();
    end

    // R7: cycle write restarts the period counter
    start_cfg(4, 1);
    for (int t = 1; t <= 8; t++) begin
      if (t >= 3) check(irq, (t >= 7), "R7 period", t);
      if (t == 2) drive(2'd1, 16'h0004);
      step();
    end

    summary();
    $finish;
  end
endmodule